// File: doc/BRIEF.md
# Programmable Master and Serial Clock-Enable Divider

This block turns a fast input clock into three single-cycle enable strobes that run the slower parts of a serial codec port. The first stage divides the input clock by an integer ratio from 1 to 5 to make the device master rate. The second stage counts master-rate strobes and divides them by 8, 4, 2 or 1 to make the serial bit rate. A third, fixed stage counts master-rate strobes to make the sample-event strobe. Both ratios come from fields of one 8-bit configuration byte, and the block only reads that byte.

All logic runs on the one input clock. Each divided rate is an enable pulse and not a derived clock. A new ratio is taken into a counter only when that counter reaches its terminal count, so a period that has already started always runs to its full length and no short pulse appears.

Top module: `clkdiv_top`

## Requirements
- R1: Master field `clk_cfg[6:4]` codes 3'b000, 3'b001, 3'b010, 3'b011 and 3'b100 make `dm_en` pulse once every 1, 2, 3, 4 and 5 input clock cycles. For ratios above 1, each pulse is high for exactly one cycle.
- R2: Master field codes 3'b101, 3'b110 and 3'b111 give a ratio of 1, so `dm_en` is high on every cycle.
- R3: While `rst` is high, all three outputs are low. Reset selects a master ratio of 1, so `dm_en` is high in the first cycle after reset is released. The configured master ratio applies from that pulse on.
- R4: Serial field `clk_cfg[3:2]` codes 2'b00, 2'b01, 2'b10 and 2'b11 make `sclk_en` pulse once every 8, 4, 2 and 1 `dm_en` pulses. In steady state this is master ratio times serial ratio input cycles. Each `sclk_en` pulse comes in the cycle right after the `dm_en` pulse that completes its count.
- R5: Reset selects a serial ratio of 8. The first `sclk_en` after reset comes in the cycle after the 8th `dm_en` pulse, whatever the serial field holds.
- R6: `sample_stb` pulses once every 256 `dm_en` pulses, in the cycle after the completing `dm_en` pulse. Its period does not depend on the serial field.
- R7: A change to the master field is applied at the next master terminal count. The `dm_en` interval already in progress keeps the old ratio, and the intervals after it use the new one.
- R8: A change to the serial field is applied at the next serial terminal count. The `sclk_en` interval already in progress keeps the old ratio.
- R9: Bits 7, 1 and 0 of `clk_cfg` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input master clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_cfg | input | 8 | Configuration byte: master code in [6:4], serial code in [3:2] |
| dm_en | output | 1 | Device master-rate enable strobe |
| sclk_en | output | 1 | Serial bit-rate enable strobe |
| sample_stb | output | 1 | Sample-event strobe |

## Verification
The assertions assume that `rst` is held for at least one clock edge before checking starts. They also assume that `clk_cfg` is steady at each clock edge, because a field is sampled only at a terminal count. They place no other limit on the field values, since every code, including the unused master codes, is decoded. The stimulus changes `clk_cfg` and `rst` only on falling clock edges. It changes the fields only right after an observed strobe, so each period is either fully old or fully new and its expected length is known.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int MCODE_W = 3;
  localparam int SCODE_W = 2;
  localparam int MCNT_W  = 3;
  localparam int SCNT_W  = 3;

  // Terminal value (ratio minus one) for the master field; unused codes fall back to 1
  function automatic logic [MCNT_W-1:0] mdiv_limit(input logic [MCODE_W-1:0] code);
    case (code)
      3'd0, 3'd1, 3'd2, 3'd3, 3'd4: return MCNT_W'(code);
      default:                      return '0;
    endcase
  endfunction

  // Terminal value for the serial field: /8, /4, /2, /1
  function automatic logic [SCNT_W-1:0] sdiv_limit(input logic [SCODE_W-1:0] code);
    case (code)
      2'd0:    return 3'd7;
      2'd1:    return 3'd3;
      2'd2:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/cd_master_div.sv
module cd_master_div
  import clkdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [MCODE_W-1:0] code,
  output logic               dm_en
);
  logic [MCNT_W-1:0] cnt;
  logic [MCNT_W-1:0] lim;
  logic              term;

  assign term = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      lim   <= '0;
      dm_en <= 1'b0;
    end else begin
      dm_en <= term;
      if (term) begin
        cnt <= '0;
        lim <= mdiv_limit(code);
      end else begin
        cnt <= cnt + MCNT_W'(1);
      end
    end
  end

  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst) cnt <= lim);
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    (dm_en && lim != '0) |=> !dm_en);
  assert_ratio_at_term_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(lim) |-> $past(term));
endmodule

// File: rtl/cd_serial_div.sv
module cd_serial_div
  import clkdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               dm_en,
  input  logic [SCODE_W-1:0] code,
  output logic               sclk_en
);
  logic [SCNT_W-1:0] cnt;
  logic [SCNT_W-1:0] lim;
  logic              term;

  assign term = dm_en && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      lim     <= sdiv_limit('0);
      sclk_en <= 1'b0;
    end else begin
      sclk_en <= term;
      if (dm_en) begin
        if (term) begin
          cnt <= '0;
          lim <= sdiv_limit(code);
        end else begin
          cnt <= cnt + SCNT_W'(1);
        end
      end
    end
  end

  assert_follows_master_R4: assert property (@(posedge clk) disable iff (rst)
    sclk_en |-> $past(dm_en));
  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst) cnt <= lim);
  assert_hold_without_enable_R4: assert property (@(posedge clk) disable iff (rst)
    !dm_en |=> $stable(cnt));
  assert_ratio_at_term_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(lim) |-> $past(term));
endmodule

// File: rtl/cd_sample_div.sv
module cd_sample_div #(
  parameter int SAMPLE_DIV = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic dm_en,
  output logic sample_stb
);
  logic term;

  generate
    if (SAMPLE_DIV <= 1) begin : g_pass
      assign term = dm_en;
    end else begin : g_count
      localparam int CW = $clog2(SAMPLE_DIV);
      logic [CW-1:0] cnt;
      assign term = dm_en && (cnt == CW'(SAMPLE_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (term) cnt <= '0;
        else if (dm_en) cnt <= cnt + CW'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sample_stb <= 1'b0;
    else     sample_stb <= term;
  end

  assert_follows_master_R6: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> $past(dm_en));
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
#(
  parameter int CFG_W      = 8,
  parameter int MCODE_LSB  = 4,
  parameter int SCODE_LSB  = 2,
  parameter int SAMPLE_DIV = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] clk_cfg,
  output logic             dm_en,
  output logic             sclk_en,
  output logic             sample_stb
);
  localparam int MCODE_MSB = MCODE_LSB + MCODE_W - 1;
  localparam int SCODE_MSB = SCODE_LSB + SCODE_W - 1;

  logic [MCODE_W-1:0] mcode;
  logic [SCODE_W-1:0] scode;
  logic               unused_cfg_bits;

  assign mcode           = clk_cfg[MCODE_MSB:MCODE_LSB];
  assign scode           = clk_cfg[SCODE_MSB:SCODE_LSB];
  assign unused_cfg_bits = ^{clk_cfg[CFG_W-1], clk_cfg[SCODE_LSB-1:0]};

  cd_master_div u_master (
    .clk   (clk),
    .rst   (rst),
    .code  (mcode),
    .dm_en (dm_en)
  );

  cd_serial_div u_serial (
    .clk     (clk),
    .rst     (rst),
    .dm_en   (dm_en),
    .code    (scode),
    .sclk_en (sclk_en)
  );

  cd_sample_div #(.SAMPLE_DIV(SAMPLE_DIV)) u_sample (
    .clk        (clk),
    .rst        (rst),
    .dm_en      (dm_en),
    .sample_stb (sample_stb)
  );

  assert_reset_quiet_R3: assert property (@(posedge clk) rst |=> !(dm_en || sclk_en || sample_stb));
endmodule

// File: tb/clkdiv_top_tb_top.sv
`timescale 1ns/1ps
module clkdiv_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] clk_cfg = 8'h00;
  logic       dm_en, sclk_en, sample_stb;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  clkdiv_top dut_i (
    .clk        (clk),
    .rst        (rst),
    .clk_cfg    (clk_cfg),
    .dm_en      (dm_en),
    .sclk_en    (sclk_en),
    .sample_stb (sample_stb)
  );

  function automatic logic [7:0] mk(input logic [2:0] m, input logic [1:0] s, input logic [2:0] x);
    return {x[2], m, s, x[1:0]};
  endfunction

  function automatic logic sig(input int sel);
    return (sel == 0) ? dm_en : (sel == 1) ? sclk_en : sample_stb;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Cycles from one observed pulse of the chosen strobe to the next
  task automatic gap(input int sel, output int n);
    do @(negedge clk); while (!sig(sel));
    n = 0;
    do begin @(negedge clk); n++; end while (!sig(sel));
  endtask

  task automatic do_reset(input logic [7:0] cfg);
    rst = 1'b1;
    clk_cfg = cfg;
    repeat (3) @(negedge clk);
    check("R3 outputs low in reset", {29'd0, dm_en, sclk_en, sample_stb}, 0);
    rst = 1'b0;
  endtask

  task automatic t_reset_master;
    int n;
    do_reset(mk(3'd4, 2'd0, 3'd0));
    @(negedge clk);
    check("R3 dm_en right after release", int'(dm_en), 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!dm_en);
    check("R3 new ratio from first pulse", n, 5);
  endtask

  task automatic t_master_codes;
    int n;
    int exp;
    for (int c = 0; c < 8; c++) begin
      clk_cfg = mk(3'(c), 2'd3, 3'd0);
      gap(0, n);
      gap(0, n);
      gap(0, n);
      exp = (c < 5) ? c + 1 : 1;
      if (c < 5) check("R1 master ratio", n, exp);
      else       check("R2 unused master code", n, exp);
    end
  endtask

  task automatic t_serial_reset;
    int cnt;
    for (int m = 0; m < 3; m += 2) begin
      do_reset(mk(3'(m), 2'd3, 3'd0));
      cnt = 0;
      @(negedge clk);
      while (!sclk_en) begin
        if (dm_en) cnt++;
        @(negedge clk);
      end
      check("R5 first serial period", cnt, 8);
    end
  endtask

  task automatic t_serial_codes;
    int n;
    logic prev_dm;
    for (int m = 0; m < 3; m += 2) begin
      for (int s = 0; s < 4; s++) begin
        clk_cfg = mk(3'(m), 2'(s), 3'd0);
        repeat (3) gap(1, n);
        check("R4 serial ratio", n, (m + 1) * (8 >> s));
      end
    end
    clk_cfg = mk(3'd2, 2'd3, 3'd0);
    repeat (3) gap(1, n);
    prev_dm = 1'b0;
    do begin prev_dm = dm_en; @(negedge clk); end while (!sclk_en);
    check("R4 sclk_en follows dm_en", {30'd0, prev_dm, dm_en}, 2);
  endtask

  task automatic t_sample;
    int n;
    clk_cfg = mk(3'd0, 2'd0, 3'd0);
    gap(2, n); gap(2, n);
    check("R6 sample at master /1", n, 256);
    clk_cfg = mk(3'd1, 2'd3, 3'd0);
    gap(2, n); gap(2, n);
    check("R6 sample at master /2", n, 512);
    clk_cfg = mk(3'd1, 2'd0, 3'd0);
    gap(2, n);
    check("R6 sample ignores serial code", n, 512);
  endtask

  task automatic t_master_change;
    int n;
    clk_cfg = mk(3'd3, 2'd3, 3'd0);
    repeat (3) gap(0, n);
    clk_cfg = mk(3'd1, 2'd3, 3'd0);
    n = 0;
    do begin @(negedge clk); n++; end while (!dm_en);
    check("R7 old master period completes", n, 4);
    n = 0;
    do begin @(negedge clk); n++; end while (!dm_en);
    check("R7 new master period", n, 2);
  endtask

  task automatic t_serial_change;
    int n;
    clk_cfg = mk(3'd0, 2'd1, 3'd0);
    repeat (3) gap(1, n);
    clk_cfg = mk(3'd0, 2'd2, 3'd0);
    n = 0;
    do begin @(negedge clk); n++; end while (!sclk_en);
    check("R8 old serial period completes", n, 4);
    n = 0;
    do begin @(negedge clk); n++; end while (!sclk_en);
    check("R8 new serial period", n, 2);
  endtask

  task automatic t_ignored_bits;
    int n;
    clk_cfg = mk(3'd2, 2'd2, 3'd7);
    repeat (3) gap(0, n);
    check("R9 spare bits, master", n, 3);
    repeat (3) gap(1, n);
    check("R9 spare bits, serial", n, 6);
    clk_cfg = mk(3'd0, 2'd0, 3'd5);
    gap(2, n); gap(2, n);
    check("R9 spare bits, sample", n, 256);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_master();
    t_master_codes();
    t_serial_reset();
    t_serial_codes();
    t_sample();
    t_master_change();
    t_serial_change();
    t_ignored_bits();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule